// File: doc/BRIEF.md
# Host Command Vector Handshake

This block is a host-facing control register. It lets an external host processor ask a signal-processing core to run a chosen interrupt handler. The host writes one byte over a simple write-strobe bus. The low seven bits choose one of 128 handlers. The top bit raises a command request. The block presents a pending flag and a handler address to the core's interrupt logic. The handler address is the chosen vector doubled.

The core answers with a one-cycle acknowledge pulse, and that pulse drops the request. The host reads the byte back to see when its command has been taken. While a request is still outstanding, the register refuses host writes. Any such refused write raises a sticky protocol-error flag.

There are two kinds of reset. One is an asynchronous hardware reset. The other is a vector of synchronous reset sources (software, individual and stop). Every reset restores the same state.

Top module: `hostcmd_vector`

## Requirements
- R1: While `rst_n` is low, `host_rdata` reads 0x32 (request bit 7 = 0, vector 0x32), `cmd_pending` is 0, `vec_addr` is 0x64 and `proto_err` is 0.
- R2: A clock edge with any bit of `sync_rst` high restores the R1 state. This holds whatever `host_wr_en` and `core_ack` are doing at that edge.
- R3: With the request bit clear, a write whose bit 7 is 0 loads bits 6..0 into the vector at the next edge. `cmd_pending` stays 0.
- R4: With the request bit clear, a write whose bit 7 is 1 sets the request bit and loads the vector in the same edge. `cmd_pending` rises in that same cycle and stays equal to read-back bit 7.
- R5: `vec_addr` always equals the current vector multiplied by two.
- R6: A `core_ack` at an edge where the request bit is set clears the request bit. `cmd_pending` falls in the same cycle. The vector is kept.
- R7: A write at an edge where the request bit is set is discarded, so `host_rdata` is unchanged by it. It sets `proto_err`.
- R8: A `core_ack` at an edge where the request bit is clear has no effect on `host_rdata`.
- R9: If a write and `core_ack` arrive at the same edge while the request bit is set, the acknowledge clears the request bit. The write is discarded and `proto_err` is set.
- R10: Once set, `proto_err` stays high until a reset of either kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| sync_rst | input | NUM_SRST (3) | Synchronous reset sources (software, individual, stop), active high |
| host_wr_en | input | 1 | Host write strobe for the command byte |
| host_wdata | input | DATA_W (8) | Host write byte: bit 7 request, bits 6..0 vector |
| core_ack | input | 1 | One-cycle acknowledge from the core's interrupt logic |
| host_rdata | output | DATA_W (8) | Read-back of the request bit and the vector |
| cmd_pending | output | 1 | Command-pending flag toward the core |
| vec_addr | output | ADDR_W (8) | Handler address, vector times two |
| proto_err | output | 1 | Sticky flag for writes refused during lockout |

## Verification
Two events can fall on the same edge while a request is outstanding: the core's acknowledge and a host write. The bench provokes this by driving `core_ack` and `host_wr_en` together in one cycle after a request has been raised. It then expects three results: the request bit clear, the vector unchanged and `proto_err` set.

A second collision puts a synchronous reset on the same edge as a write or an acknowledge. The bench checks that the reset state wins in full. The scoreboard's reference model is derived from the requirements alone. It judges each cycle's read-back, pending flag, address and error flag.

// File: rtl/hcv_pkg.sv
package hcv_pkg;

   // Outcome of a host write strobe at a clock edge.
   typedef enum logic [1:0] {
      HCV_WR_NONE    = 2'd0,
      HCV_WR_ACCEPT  = 2'd1,
      HCV_WR_BLOCKED = 2'd2
   } hcv_wr_e;

   localparam int HCV_DEF_DATA_W    = 8;
   localparam int HCV_DEF_RESET_VEC = 'h32;

endpackage

// File: rtl/hcv_rst_merge.sv
module hcv_rst_merge #(
   parameter int NUM_SRC = 3
) (
   input  logic [NUM_SRC-1:0] src,
   output logic               any_rst
);

   initial begin
      if (NUM_SRC < 1) $fatal(1, "hcv_rst_merge: NUM_SRC must be at least 1");
   end

   generate
      if (NUM_SRC == 1) begin : g_single
         assign any_rst = src[0];
      end else begin : g_multi
         assign any_rst = |src;
      end
   endgenerate

endmodule

// File: rtl/hcv_ctrl_reg.sv
module hcv_ctrl_reg
   import hcv_pkg::*;
#(
   parameter int VEC_W     = 7,
   parameter int RESET_VEC = 'h32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sync_clr,
   input  logic             wr_en,
   input  logic [VEC_W:0]   wdata,
   input  logic             ack,
   output logic             req,
   output logic [VEC_W-1:0] vec,
   output logic             err
);

   localparam logic [VEC_W-1:0] VecInit = VEC_W'(RESET_VEC);

   hcv_wr_e wr_kind;

   // Lockout is judged on the request bit held before the edge.
   always_comb begin
      if (!wr_en)   wr_kind = HCV_WR_NONE;
      else if (req) wr_kind = HCV_WR_BLOCKED;
      else          wr_kind = HCV_WR_ACCEPT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req <= 1'b0;
         vec <= VecInit;
         err <= 1'b0;
      end else if (sync_clr) begin
         req <= 1'b0;
         vec <= VecInit;
         err <= 1'b0;
      end else begin
         if (wr_kind == HCV_WR_ACCEPT) begin
            req <= wdata[VEC_W];
            vec <= wdata[VEC_W-1:0];
         end else if (ack && req) begin
            req <= 1'b0;
         end
         if (wr_kind == HCV_WR_BLOCKED) begin
            err <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/hcv_addr_map.sv
module hcv_addr_map #(
   parameter int VEC_W  = 7,
   parameter int SHIFT  = 1,
   parameter int ADDR_W = VEC_W + SHIFT
) (
   input  logic [VEC_W-1:0]  vec,
   output logic [ADDR_W-1:0] addr
);

   initial begin
      if (ADDR_W != VEC_W + SHIFT) $fatal(1, "hcv_addr_map: ADDR_W must equal VEC_W + SHIFT");
      if (SHIFT < 0) $fatal(1, "hcv_addr_map: SHIFT must not be negative");
   end

   generate
      if (SHIFT == 0) begin : g_direct
         assign addr = vec;
      end else begin : g_scaled
         assign addr = {vec, {SHIFT{1'b0}}};
      end
   endgenerate

endmodule

// File: rtl/hostcmd_vector.sv
module hostcmd_vector
   import hcv_pkg::*;
#(
   parameter int DATA_W     = HCV_DEF_DATA_W,
   parameter int ADDR_SHIFT = 1,
   parameter int ADDR_W     = DATA_W - 1 + ADDR_SHIFT,
   parameter int RESET_VEC  = HCV_DEF_RESET_VEC,
   parameter int NUM_SRST   = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRST-1:0] sync_rst,
   input  logic                host_wr_en,
   input  logic [DATA_W-1:0]   host_wdata,
   input  logic                core_ack,
   output logic [DATA_W-1:0]   host_rdata,
   output logic                cmd_pending,
   output logic [ADDR_W-1:0]   vec_addr,
   output logic                proto_err
);

   localparam int VEC_W = DATA_W - 1;

   initial begin
      if (DATA_W < 2) $fatal(1, "hostcmd_vector: DATA_W must be at least 2");
      if (ADDR_W != VEC_W + ADDR_SHIFT) $fatal(1, "hostcmd_vector: ADDR_W inconsistent");
      if (RESET_VEC < 0 || RESET_VEC >= (1 << VEC_W)) $fatal(1, "hostcmd_vector: RESET_VEC out of range");
      if (NUM_SRST < 1) $fatal(1, "hostcmd_vector: NUM_SRST must be at least 1");
   end

   logic             any_srst;
   logic             req_q;
   logic [VEC_W-1:0] vec_q;
   logic             err_q;

   hcv_rst_merge #(.NUM_SRC(NUM_SRST)) u_rst (
      .src     (sync_rst),
      .any_rst (any_srst)
   );

   hcv_ctrl_reg #(.VEC_W(VEC_W), .RESET_VEC(RESET_VEC)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_clr (any_srst),
      .wr_en    (host_wr_en),
      .wdata    (host_wdata),
      .ack      (core_ack),
      .req      (req_q),
      .vec      (vec_q),
      .err      (err_q)
   );

   hcv_addr_map #(.VEC_W(VEC_W), .SHIFT(ADDR_SHIFT), .ADDR_W(ADDR_W)) u_map (
      .vec  (vec_q),
      .addr (vec_addr)
   );

   assign host_rdata  = {req_q, vec_q};
   assign cmd_pending = req_q;
   assign proto_err   = err_q;

endmodule

// File: rtl/hcv_checker.sv
module hcv_checker #(
   parameter int DATA_W     = 8,
   parameter int ADDR_SHIFT = 1,
   parameter int ADDR_W     = DATA_W - 1 + ADDR_SHIFT,
   parameter int RESET_VEC  = 'h32,
   parameter int NUM_SRST   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic [NUM_SRST-1:0] sync_rst,
   input logic                host_wr_en,
   input logic [DATA_W-1:0]   host_wdata,
   input logic                core_ack,
   input logic [DATA_W-1:0]   host_rdata,
   input logic                cmd_pending,
   input logic [ADDR_W-1:0]   vec_addr,
   input logic                proto_err
);

   localparam int VEC_W = DATA_W - 1;
   localparam logic [DATA_W-1:0] RdInit = DATA_W'(RESET_VEC);

   logic req;
   logic srst;
   assign req  = host_rdata[VEC_W];
   assign srst = |sync_rst;

   p_rst_state_r2: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (host_rdata == RdInit && !proto_err && !cmd_pending));

   p_load_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !req && host_wr_en) |=> host_rdata == $past(host_wdata));

   p_pending_tracks_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_pending == req);

   p_addr_map_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vec_addr == ADDR_W'({host_rdata[VEC_W-1:0], {ADDR_SHIFT{1'b0}}}));

   p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && req && core_ack) |=> (!req && !cmd_pending));

   p_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && req && host_wr_en && !core_ack) |=> ($stable(host_rdata) && proto_err));

   p_idle_ack_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && !req && core_ack && !host_wr_en) |=> $stable(host_rdata));

   p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!srst && req && host_wr_en && core_ack) |=>
         (!req && proto_err && host_rdata[VEC_W-1:0] == $past(host_rdata[VEC_W-1:0])));

   p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (proto_err && !srst) |=> proto_err);

endmodule

bind hostcmd_vector hcv_checker #(
   .DATA_W     (DATA_W),
   .ADDR_SHIFT (ADDR_SHIFT),
   .ADDR_W     (ADDR_W),
   .RESET_VEC  (RESET_VEC),
   .NUM_SRST   (NUM_SRST)
) u_hcv_checker (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_rst    (sync_rst),
   .host_wr_en  (host_wr_en),
   .host_wdata  (host_wdata),
   .core_ack    (core_ack),
   .host_rdata  (host_rdata),
   .cmd_pending (cmd_pending),
   .vec_addr    (vec_addr),
   .proto_err   (proto_err)
);

// File: tb/hostcmd_vector_bench.sv
module hostcmd_vector_bench;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [7:0] rd;
      logic       pend;
      logic [7:0] addr;
      logic       err;
      string      tag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] sync_rst = '0;
   logic       host_wr_en = 1'b0;
   logic [7:0] host_wdata = '0;
   logic       core_ack = 1'b0;
   logic [7:0] host_rdata;
   logic       cmd_pending;
   logic [7:0] vec_addr;
   logic       proto_err;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   exp_t sb_q[$];

   // reference model state, from the requirements
   logic       m_req = 1'b0;
   logic [6:0] m_vec = 7'h32;
   logic       m_err = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hostcmd_vector u_hostcmd_vector (
      .clk         (clk),
      .rst_n       (rst_n),
      .sync_rst    (sync_rst),
      .host_wr_en  (host_wr_en),
      .host_wdata  (host_wdata),
      .core_ack    (core_ack),
      .host_rdata  (host_rdata),
      .cmd_pending (cmd_pending),
      .vec_addr    (vec_addr),
      .proto_err   (proto_err)
   );

   task automatic compare(input exp_t e);
      checks++;
      if (host_rdata !== e.rd || cmd_pending !== e.pend ||
          vec_addr !== e.addr || proto_err !== e.err) begin
         failures++;
         $display("FAIL %s: rdata=%h pend=%b addr=%h err=%b expected rdata=%h pend=%b addr=%h err=%b",
                  e.tag, host_rdata, cmd_pending, vec_addr, proto_err,
                  e.rd, e.pend, e.addr, e.err);
      end
   endtask

   function automatic exp_t model_now(input string tag);
      exp_t e;
      e.rd   = {m_req, m_vec};
      e.pend = m_req;
      e.addr = {m_vec, 1'b0};
      e.err  = m_err;
      e.tag  = tag;
      return e;
   endfunction

   // driver: one cycle of stimulus, expected result pushed to the scoreboard
   task automatic step(input logic wr, input logic [7:0] d, input logic ack,
                       input logic [2:0] sr, input string tag);
      logic was;
      @(negedge clk);
      host_wr_en = wr;
      host_wdata = d;
      core_ack   = ack;
      sync_rst   = sr;
      if (|sr) begin
         m_req = 1'b0; m_vec = 7'h32; m_err = 1'b0;
      end else begin
         was = m_req;
         if (wr && was) m_err = 1'b1;
         if (ack && was) m_req = 1'b0;
         if (wr && !was) begin
            m_req = d[7];
            m_vec = d[6:0];
         end
      end
      sb_q.push_back(model_now(tag));
   endtask

   task automatic idle(input string tag);
      step(1'b0, 8'h00, 1'b0, 3'b000, tag);
   endtask

   // monitor: compare after each edge, away from the edge itself
   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) compare(sb_q.pop_front());
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(CLK_PERIOD * 2 + 1);
      // R1: hardware reset state
      compare(model_now("R1 reset"));
      @(negedge clk);
      rst_n = 1'b1;

      step(1'b0, 8'h00, 1'b1, 3'b000, "R8 ack while idle");
      step(1'b1, 8'h05, 1'b0, 3'b000, "R3 plain vector load");
      step(1'b1, 8'h7F, 1'b0, 3'b000, "R5 top vector address");
      step(1'b1, 8'h00, 1'b0, 3'b000, "R5 zero vector address");
      step(1'b1, 8'h91, 1'b0, 3'b000, "R4 request with vector");
      idle("R4 request held");
      step(1'b1, 8'h22, 1'b0, 3'b000, "R7 write during lockout");
      step(1'b1, 8'h00, 1'b0, 3'b000, "R7 second locked write");
      idle("R10 error stays");
      step(1'b0, 8'h00, 1'b1, 3'b000, "R6 ack clears request");
      idle("R10 error stays after ack");
      step(1'b0, 8'h00, 1'b0, 3'b001, "R2 software reset source");
      step(1'b1, 8'hC0, 1'b0, 3'b000, "R4 request vector 0x40");
      step(1'b1, 8'h01, 1'b1, 3'b000, "R9 write with ack");
      idle("R9 after collision");
      step(1'b1, 8'h85, 1'b0, 3'b010, "R2 individual reset beats write");
      step(1'b1, 8'h9A, 1'b0, 3'b000, "R4 request vector 0x1A");
      step(1'b0, 8'h00, 1'b1, 3'b100, "R2 stop reset beats ack");
      step(1'b1, 8'h3C, 1'b1, 3'b000, "R8 ack and write while idle");
      step(1'b1, 8'hFF, 1'b0, 3'b000, "R4 request vector 0x7F");
      idle("R4 idle hold");
      idle("drain");
      @(negedge clk);

      // R1: asynchronous reset during an outstanding request
      rst_n = 1'b0;
      #1;
      m_req = 1'b0; m_vec = 7'h32; m_err = 1'b0;
      compare(model_now("R1 async reset mid request"));
      @(negedge clk);
      rst_n = 1'b1;
      idle("R1 state after release");
      idle("drain");
      @(negedge clk);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule